// File: doc/BRIEF.md
# NIC Command and Status Register Unit

This block is the system-control register set of a network controller. Software reaches it over a plain 32-bit register bus with byte strobes. Word 0 holds the 16-bit status word in its low half and the 16-bit command word in its high half. Word 1 holds a 32-bit general pointer, which gives the operand (a base or descriptor address) for start and load commands. Reads are combinational on the addressed word.

Six event inputs come from the command unit, the receive unit, the management interface and flow control. A software trigger in the command word adds a seventh. Each event sets a sticky bit in the status word. Software acknowledges events by writing ones to them. The live states of the command and receive units are shown in the low status byte. A command byte loads a command-unit opcode and a receive-unit opcode. Each opcode field stays nonzero until its unit returns a one-cycle accept pulse, so software can poll for zero before it issues the next command. An interrupt request is raised while any event is pending and the mask bit in the command word is clear.

Top module: `nic_scb`

## Requirements
- R1: After synchronous active-low reset, all event bits, both opcode fields, the mask bit and the pointer are zero, and `irq_o` is low.
- R2: An event input that is high in a cycle sets its status bit from the next cycle on, and the bit stays set until it is acknowledged. The status bits are: command done 15, frame received 14, command unit left active 13, receiver left ready 12, management cycle done 11, software interrupt 10, flow-control pause 8.
- R3: A write to word 0 with byte strobe 1 clears exactly those event bits written as 1 in data bits 15:8. A write without that strobe clears nothing.
- R4: When an event input is high in the same cycle as the write that clears its bit, the bit stays set.
- R5: Status bits 7:6 show `cu_state_i` and bits 5:2 show `ru_state_i` with no delay. Status bits 9, 1 and 0 read as zero.
- R6: A write to word 0 with byte strobe 2 loads data bits 23:20 into the command-unit opcode and bits 18:16 into the receive-unit opcode, one cycle later. The fields read back at the same positions. Bit 19 reads as zero.
- R7: An accept pulse clears its own opcode field in the next cycle and leaves the other field unchanged.
- R8: A command write in the same cycle as an accept keeps the newly written opcode.
- R9: A write with byte strobe 3 stores data bit 24 as the mask, which reads back at bit 24. `irq_o` is high exactly when some event bit is pending and the mask is zero.
- R10: Writing 1 to data bit 25 with byte strobe 3 sets status bit 10. Bit 25 always reads as zero.
- R11: Writes to word 1 update only the bytes whose strobes are set. The pointer is visible on `ptr_o` and reads back on word 1.
- R12: Words 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word index (0 control, 1 pointer) |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| ev_cu_done | input | 1 | Command unit finished a command |
| ev_frame_rx | input | 1 | Frame received |
| ev_cu_left_active | input | 1 | Command unit left the active state |
| ev_ru_left_ready | input | 1 | Receive unit left the ready state |
| ev_mgmt_done | input | 1 | Management read/write cycle done |
| ev_fc_pause | input | 1 | Flow-control pause event |
| cu_state_i | input | 2 | Command-unit state |
| ru_state_i | input | 4 | Receive-unit state |
| cu_accept | input | 1 | Command unit took its opcode |
| ru_accept | input | 1 | Receive unit took its opcode |
| cu_cmd_o | output | 4 | Pending command-unit opcode |
| ru_cmd_o | output | 3 | Pending receive-unit opcode |
| ptr_o | output | 32 | General pointer operand |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that events stick and that an event beats a clear in the same cycle. They also check that an acknowledge clears a bit, that an accept empties its field unless a write arrives with it, that the software trigger lands, that the mask holds the interrupt low, and that reserved bits read as zero. Only the bench scenarios can show that the whole event byte follows a given set and clear pattern, and that every command byte maps to the right pair of opcode fields. The same holds for the live state encodings and the per-byte merge of the pointer, which the bench sweeps over all values.

// File: rtl/nic_scb_pkg.sv
// Package: shared widths, word indices and bit positions of the
// command/status register unit. Assumes a 32-bit little-endian bus.
package nic_scb_pkg;
    localparam int BUS_W      = 32;
    localparam int BE_W       = BUS_W / 8;
    localparam int EV_N       = 7;   // latched event bits
    localparam int CU_W       = 4;   // command-unit opcode width
    localparam int RU_W       = 3;   // receive-unit opcode width
    localparam int CU_ST_W    = 2;
    localparam int RU_ST_W    = 4;
    localparam int WORD_CTRL  = 0;
    localparam int WORD_PTR   = 1;
    localparam int LANE_ACK   = 1;   // status high byte
    localparam int LANE_CMD   = 2;   // command low byte
    localparam int LANE_HI    = 3;   // command high byte
    localparam int BIT_MASK   = 24;
    localparam int BIT_SWI    = 25;
    localparam int CU_LSB     = 20;
    localparam int RU_LSB     = 16;
endpackage

// File: rtl/scb_event_latch.sv
// Sticky event bits with write-one-to-clear. A set in the same cycle
// as a clear wins. Assumes set/clear vectors are already decoded.
module scb_event_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        // Hold, set or acknowledge one event bit.
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= set_i[i] | (bit_q & ~clr_i[i]);
        end
        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/scb_cmd_field.sv
// Self-clearing opcode field: loaded by a write, emptied by the target
// unit's accept pulse. A write beats an accept in the same cycle.
module scb_cmd_field #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         accept_i,
    output logic [W-1:0] field_o
);
    logic [W-1:0] field_q;

    // Load on write, clear on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)        field_q <= '0;
        else if (wr_i)     field_q <= data_i;
        else if (accept_i) field_q <= '0;
    end

    assign field_o = field_q;
endmodule

// File: rtl/scb_word_reg.sv
// Byte-strobed read/write register with a reset value of zero.
// Assumes the write enable is already qualified by the address.
module scb_word_reg #(
    parameter int BYTES = 4,
    localparam int W    = BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [BYTES-1:0] be_i,
    input  logic [W-1:0]     data_i,
    output logic [W-1:0]     q_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [7:0] byte_q;
        // Update one byte lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n)               byte_q <= '0;
            else if (wr_i && be_i[b]) byte_q <= data_i[8*b +: 8];
        end
        assign q_o[8*b +: 8] = byte_q;
    end
endmodule

// File: rtl/nic_scb.sv
// Top: command/status register unit of a network controller.
// Word 0 = {command[15:0], status[15:0]}, word 1 = pointer.
// Assumes single-cycle bus writes and combinational reads.
module nic_scb
    import nic_scb_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ev_cu_done,
    input  logic              ev_frame_rx,
    input  logic              ev_cu_left_active,
    input  logic              ev_ru_left_ready,
    input  logic              ev_mgmt_done,
    input  logic              ev_fc_pause,
    input  logic [CU_ST_W-1:0] cu_state_i,
    input  logic [RU_ST_W-1:0] ru_state_i,
    input  logic              cu_accept,
    input  logic              ru_accept,
    output logic [CU_W-1:0]   cu_cmd_o,
    output logic [RU_W-1:0]   ru_cmd_o,
    output logic [BUS_W-1:0]  ptr_o,
    output logic              irq_o
);
    logic             wr_ctrl, wr_ptr, swi_pulse, mask_q;
    logic [EV_N-1:0]  ev_set, ev_clr, ev_q;
    logic [15:0]      status_w, cmd_w;

    // Address decode of the two writable words.
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(WORD_CTRL));
    assign wr_ptr  = bus_wr && (bus_addr == ADDR_W'(WORD_PTR));

    // Software trigger and event vector (bit 1 = software event).
    assign swi_pulse = wr_ctrl && bus_be[LANE_HI] && bus_wdata[BIT_SWI];
    assign ev_set = {ev_cu_done, ev_frame_rx, ev_cu_left_active,
                     ev_ru_left_ready, ev_mgmt_done, swi_pulse, ev_fc_pause};
    assign ev_clr = (wr_ctrl && bus_be[LANE_ACK])
                  ? {bus_wdata[15:10], bus_wdata[8]} : '0;

    scb_event_latch #(.N(EV_N)) u_events (
        .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(ev_clr), .q_o(ev_q)
    );

    scb_cmd_field #(.W(CU_W)) u_cu_field (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl && bus_be[LANE_CMD]),
        .data_i(bus_wdata[CU_LSB +: CU_W]), .accept_i(cu_accept),
        .field_o(cu_cmd_o)
    );

    scb_cmd_field #(.W(RU_W)) u_ru_field (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl && bus_be[LANE_CMD]),
        .data_i(bus_wdata[RU_LSB +: RU_W]), .accept_i(ru_accept),
        .field_o(ru_cmd_o)
    );

    scb_word_reg #(.BYTES(BE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ptr), .be_i(bus_be),
        .data_i(bus_wdata), .q_o(ptr_o)
    );

    // Interrupt mask bit, written through the command high byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_q <= 1'b0;
        else if (wr_ctrl && bus_be[LANE_HI])  mask_q <= bus_wdata[BIT_MASK];
    end

    // Pending, unmasked events request an interrupt.
    assign irq_o = (|ev_q) && !mask_q;

    // Assemble the readable status and command halves.
    assign status_w = {ev_q[6:1], 1'b0, ev_q[0], cu_state_i, ru_state_i, 2'b00};
    assign cmd_w    = {6'b0, 1'b0, mask_q, cu_cmd_o, 1'b0, ru_cmd_o};

    // Read mux over the word index.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(WORD_CTRL))     bus_rdata = {cmd_w, status_w};
        else if (bus_addr == ADDR_W'(WORD_PTR)) bus_rdata = ptr_o;
    end
endmodule

// File: rtl/nic_scb_chk.sv
// Checker for nic_scb: cycle-level properties of events, acknowledge,
// opcode fields, mask and reserved bits. Bound to every nic_scb.
module nic_scb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_sel,
    input logic       bus_wr,
    input logic [3:1] be_hi,
    input logic       wd_ack15,
    input logic       wd_swi,
    input logic       ev_cu_done,
    input logic       ev_fc_pause,
    input logic       cu_accept,
    input logic       ru_accept,
    input logic [3:0] cu_cmd_o,
    input logic [2:0] ru_cmd_o,
    input logic       irq_o,
    input logic       q_done,
    input logic       q_swi,
    input logic       q_pause,
    input logic       rd_mask,
    input logic [7:0] rd_events,
    input logic [4:0] rd_zero
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && ctrl_sel;

    p_done_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cu_done |=> q_done);

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fc_pause |=> q_pause);

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && be_hi[1] && wd_ack15 && !ev_cu_done) |=> !q_done);

    p_no_ack_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_cu_done && !(ctrl_wr && be_hi[1])) |=> $stable(q_done));

    p_cu_accept_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_accept && !(ctrl_wr && be_hi[2])) |=> (cu_cmd_o == 4'd0));

    p_ru_accept_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_accept && !(ctrl_wr && be_hi[2])) |=> (ru_cmd_o == 3'd0));

    p_swi_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && be_hi[3] && wd_swi) |=> q_swi);

    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sel && rd_mask) |-> !irq_o);

    p_pending_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sel && !rd_mask && (|rd_events)) |-> irq_o);

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |-> (rd_zero == 5'd0));
endmodule

bind nic_scb nic_scb_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .ctrl_sel(bus_addr == 2'd0), .bus_wr(bus_wr), .be_hi(bus_be[3:1]),
    .wd_ack15(bus_wdata[15]), .wd_swi(bus_wdata[25]),
    .ev_cu_done(ev_cu_done), .ev_fc_pause(ev_fc_pause),
    .cu_accept(cu_accept), .ru_accept(ru_accept),
    .cu_cmd_o(cu_cmd_o), .ru_cmd_o(ru_cmd_o), .irq_o(irq_o),
    .q_done(ev_q[6]), .q_swi(ev_q[1]), .q_pause(ev_q[0]),
    .rd_mask(bus_rdata[24]), .rd_events(bus_rdata[15:8]),
    .rd_zero({bus_rdata[25], bus_rdata[19], bus_rdata[9], bus_rdata[1:0]})
);

// File: tb/tb_nic_scb.sv
// Self-checking bench: sweeps event patterns, acknowledge masks, command
// bytes, unit states and pointer strobes with arithmetic expectations.
module tb_nic_scb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  ev = '0;   // {done, frame, cu_left, ru_left, mgmt, pause}
    logic [1:0]  cu_state_i = '0;
    logic [3:0]  ru_state_i = '0;
    logic        cu_accept = 1'b0, ru_accept = 1'b0;
    logic [3:0]  cu_cmd_o;
    logic [2:0]  ru_cmd_o;
    logic [31:0] ptr_o;
    logic        irq_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nic_scb dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_cu_done(ev[5]), .ev_frame_rx(ev[4]), .ev_cu_left_active(ev[3]),
        .ev_ru_left_ready(ev[2]), .ev_mgmt_done(ev[1]), .ev_fc_pause(ev[0]),
        .cu_state_i(cu_state_i), .ru_state_i(ru_state_i),
        .cu_accept(cu_accept), .ru_accept(ru_accept),
        .cu_cmd_o(cu_cmd_o), .ru_cmd_o(ru_cmd_o), .ptr_o(ptr_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bus cycle with events and accepts; returns at the next negedge.
    task automatic step(input logic [5:0] e, input logic wr, input logic [1:0] a,
                        input logic [3:0] be, input logic [31:0] d,
                        input logic ca, input logic ra);
        @(negedge clk);
        ev = e; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
        cu_accept = ca; ru_accept = ra;
        @(negedge clk);
        ev = '0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
        cu_accept = 1'b0; ru_accept = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Status high byte expected from an event input pattern.
    function automatic logic [7:0] ev_byte(input logic [5:0] p);
        return {p[5:1], 1'b0, 1'b0, p[0]};
    endfunction

    task automatic clear_all();
        step('0, 1'b1, 2'd0, 4'b0010, 32'h0000_FF00, 1'b0, 1'b0);
    endtask

    logic [31:0] v;
    logic [31:0] pexp;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v);
        chk("R1", "word0 after reset", v, 32'h0);
        rd(2'd1, v);
        chk("R1", "pointer after reset", v, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R1", "opcodes after reset", {25'b0, cu_cmd_o, ru_cmd_o}, 32'h0);

        // R2, R3: every event input pattern latches, then full acknowledge
        for (int p = 0; p < 64; p++) begin
            step(6'(p), 1'b0, 2'd0, 4'b0, 32'h0, 1'b0, 1'b0);
            @(negedge clk);   // held for an extra idle cycle
            rd(2'd0, v);
            chk("R2", "event byte", {24'b0, v[15:8]}, {24'b0, ev_byte(6'(p))});
            clear_all();
            rd(2'd0, v);
            chk("R3", "full ack", {24'b0, v[15:8]}, 32'h0);
        end

        // R3, R9, R10: set everything, acknowledge with each possible mask
        for (int m = 0; m < 256; m++) begin
            step(6'h3F, 1'b1, 2'd0, 4'b1000, 32'h0200_0000, 1'b0, 1'b0);
            step('0, 1'b1, 2'd0, 4'b0010, {16'h0, 8'(m), 8'h00}, 1'b0, 1'b0);
            rd(2'd0, v);
            chk("R3", "partial ack", {24'b0, v[15:8]}, {24'b0, 8'hFD & ~8'(m)});
            chk("R9", "irq after ack", {31'b0, irq_o},
                {31'b0, ((8'hFD & ~8'(m)) != 8'h00)});
            clear_all();
        end

        // R3: ack data without the status strobe clears nothing
        step(6'h3F, 1'b0, 2'd0, 4'b0, 32'h0, 1'b0, 1'b0);
        step('0, 1'b1, 2'd0, 4'b1101, 32'h0000_FF00, 1'b0, 1'b0);
        rd(2'd0, v);
        chk("R3", "no strobe no clear", {24'b0, v[15:8]}, 32'h0000_00F9);
        clear_all();

        // R4: event and acknowledge in the same cycle
        step(6'h3F, 1'b0, 2'd0, 4'b0, 32'h0, 1'b0, 1'b0);
        step(6'b100001, 1'b1, 2'd0, 4'b0010, 32'h0000_FF00, 1'b0, 1'b0);
        rd(2'd0, v);
        chk("R4", "set wins over clear", {24'b0, v[15:8]}, 32'h0000_0081);
        clear_all();

        // R5: all unit state encodings read live
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 16; r++) begin
                cu_state_i = 2'(c); ru_state_i = 4'(r);
                rd(2'd0, v);
                chk("R5", "state byte", {24'b0, v[7:0]}, 32'(c * 64 + r * 4));
            end
        end
        cu_state_i = '0; ru_state_i = '0;

        // R6: every command byte loads both opcode fields
        for (int b = 0; b < 256; b++) begin
            step('0, 1'b1, 2'd0, 4'b0100, {8'h00, 8'(b), 16'h0}, 1'b0, 1'b0);
            rd(2'd0, v);
            chk("R6", "cu opcode", {28'b0, cu_cmd_o}, 32'(b / 16));
            chk("R6", "ru opcode", {29'b0, ru_cmd_o}, 32'(b % 8));
            chk("R6", "command readback", {24'b0, v[23:16]}, 32'(b & 8'hF7));
        end

        // R7: accepts clear independently
        step('0, 1'b1, 2'd0, 4'b0100, 32'h0011_0000, 1'b0, 1'b0);
        step('0, 1'b0, 2'd0, 4'b0, 32'h0, 1'b1, 1'b0);
        rd(2'd0, v);
        chk("R7", "cu accepted, ru pending", {24'b0, v[23:16]}, 32'h01);
        step('0, 1'b0, 2'd0, 4'b0, 32'h0, 1'b0, 1'b1);
        rd(2'd0, v);
        chk("R7", "both accepted", {24'b0, v[23:16]}, 32'h00);

        // R8: a write together with an accept keeps the new opcode
        step('0, 1'b1, 2'd0, 4'b0100, 32'h0057_0000, 1'b1, 1'b1);
        chk("R8", "cu opcode kept", {28'b0, cu_cmd_o}, 32'h5);
        chk("R8", "ru opcode kept", {29'b0, ru_cmd_o}, 32'h7);
        step('0, 1'b0, 2'd0, 4'b0, 32'h0, 1'b1, 1'b1);

        // R9: mask gates the interrupt
        step('0, 1'b1, 2'd0, 4'b1000, 32'h0100_0000, 1'b0, 1'b0);
        step(6'b000010, 1'b0, 2'd0, 4'b0, 32'h0, 1'b0, 1'b0);
        rd(2'd0, v);
        chk("R9", "mask readback", {31'b0, v[24]}, 32'h1);
        chk("R9", "irq masked", {31'b0, irq_o}, 32'h0);
        step('0, 1'b1, 2'd0, 4'b1000, 32'h0, 1'b0, 1'b0);
        chk("R9", "irq unmasked", {31'b0, irq_o}, 32'h1);
        clear_all();
        chk("R9", "irq idle", {31'b0, irq_o}, 32'h0);

        // R10: software trigger sets bit 10, bit 25 reads zero
        step('0, 1'b1, 2'd0, 4'b1000, 32'h0200_0000, 1'b0, 1'b0);
        rd(2'd0, v);
        chk("R10", "software event", {16'b0, v[15:0]}, 32'h0000_0400);
        chk("R10", "trigger reads zero", {31'b0, v[25]}, 32'h0);
        clear_all();

        // R11: pointer byte strobes
        pexp = 32'h0;
        for (int s = 0; s < 16; s++) begin
            logic [31:0] d;
            d = 32'h1111_1111 * (s + 1) ^ 32'hA5C3_5A3C;
            step('0, 1'b1, 2'd1, 4'(s), d, 1'b0, 1'b0);
            for (int k = 0; k < 4; k++)
                if (s[k]) pexp[8*k +: 8] = d[8*k +: 8];
            rd(2'd1, v);
            chk("R11", "pointer read", v, pexp);
            chk("R11", "pointer port", ptr_o, pexp);
        end

        // R12: unmapped words read zero
        rd(2'd2, v);
        chk("R12", "word 2", v, 32'h0);
        rd(2'd3, v);
        chk("R12", "word 3", v, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule